// File: doc/BRIEF.md
# Receive DMA request controller

This block sits between a local receive frame buffer and an ISA-style host DMA channel. When the receive side flags that a complete frame is ready, the block raises a DMA request. It then counts the host's acknowledged read cycles, using the falling edge of the active-low I/O read strobe. For each read it pulses a strobe toward the buffer and advances a byte offset into the host's receive ring. Once enough 16-bit words have moved to cover the frame length, it drops the request.

Two handshake styles are available. In demand mode the request is held through the whole frame and is released on the rising edge of the final read strobe. In single-transfer mode the request is released on the falling edge of the final read, and the acknowledge may drop between reads. An optional burst limiter caps each request window at 28 µs of clock time. After such a window the request is held off for 1.3 µs before it is raised again. The offset wraps at a host ring size of either 16 KB or 64 KB. A software reset command aborts any transfer, zeroes the offset and tells the buffer to flush.

Top module: `rxdma_req_ctrl`

## Requirements
- R1: After reset `dma_req`, `buf_rd` and `buf_flush` are 0 and `dma_ofs` is 0.
- R2: A one-cycle `frame_start` while idle with a nonzero `frame_len` raises `dma_req` on the next cycle. A `frame_len` of 0 is ignored and `dma_req` stays 0.
- R3: Each falling edge of `ior_n` seen while `dma_ack` is 1 and the request is active yields exactly one `buf_rd` pulse and a 2-byte offset step, both visible one cycle after the edge is sampled. A falling edge with `dma_ack` at 0 changes nothing.
- R4: With `cfg_single` at 0, a frame of L bytes needs ceil(L/2) reads. `dma_req` stays 1 after the last read until `ior_n` rises, and drops one cycle after that rising edge.
- R5: With `cfg_single` at 1, `dma_req` drops one cycle after the falling edge of the last read is sampled.
- R6: Each offset step computes `(dma_ofs + 2) mod 16384` when `cfg_big_buf` is 0 and `(dma_ofs + 2) mod 65536` when it is 1.
- R7: With `cfg_burst_lim` at 0, `dma_req` never drops before a frame completes, however long the frame is.
- R8: With `cfg_burst_lim` at 1, once `dma_req` has been high for ceil(28 µs × CLK_HZ) cycles and no read is in progress, it drops. It then stays low for ceil(1.3 µs × CLK_HZ) cycles and rises again while words remain. At the default 20 MHz these are 560 and 26 cycles.
- R9: A one-cycle `cmd_dma_reset` clears `dma_req` and `dma_ofs` on the next cycle and pulses `buf_flush` for one cycle. Reads that follow have no effect, and `dma_req` stays 0 until a new `frame_start`.
- R10: A `frame_start` that arrives while a frame is being transferred is ignored, and the current frame ends after its own word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_single | input | 1 | 1: single-transfer mode with early release; 0: demand mode |
| cfg_burst_lim | input | 1 | 1: limit each request window in time |
| cfg_big_buf | input | 1 | Host ring size: 1 = 64 KB, 0 = 16 KB |
| cmd_dma_reset | input | 1 | One-cycle pulse: abort, flush, zero offset |
| frame_start | input | 1 | One-cycle pulse: a complete frame is ready |
| frame_len | input | 16 | Frame length in bytes, sampled with frame_start |
| dma_ack | input | 1 | DMA acknowledge from the host |
| ior_n | input | 1 | Active-low I/O read strobe |
| dma_req | output | 1 | DMA request to the host |
| dma_ofs | output | 16 | Current byte offset into the host ring |
| buf_rd | output | 1 | One-cycle read strobe toward the frame buffer |
| buf_flush | output | 1 | One-cycle flush pulse toward the frame buffer |

## Verification
A wrong word count shows up on the very frame that carries it. `dma_req` is released one read early or one read late, and the host model sees that at the final strobe edge. A corrupted offset or a wrong wrap mask shows on `dma_ofs` one cycle after the faulty read. The bench compares it on every read, so such an error cannot hide for more than a single transfer. A timer off by one shows in the measured length of the first high or low request window after burst limiting is enabled.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_REQ   = 2'd1,
      ST_DRAIN = 2'd2,
      ST_GAP   = 2'd3
   } rxdma_state_e;

   // cycles = ceil(num_us_x10 / 10 us * clk_hz)
   function automatic longint unsigned cycles_for(input longint unsigned tenth_us,
                                                  input longint unsigned clk_hz);
      longint unsigned prod;
      prod = tenth_us * clk_hz;
      return (prod + 64'd9_999_999) / 64'd10_000_000;
   endfunction

endpackage

// File: rtl/rxdma_strobe_edge.sv
module rxdma_strobe_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ior_n,
   output logic rd_fall,
   output logic rd_rise,
   output logic rd_idle
);

   logic s_ior;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign s_ior = ior_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] ch_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ch_q <= '1;
            end else begin
               ch_q[0] <= ior_n;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  ch_q[i] <= ch_q[i-1];
               end
            end
         end
         assign s_ior = ch_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= s_ior;
   end

   assign rd_fall = prev_q & ~s_ior;
   assign rd_rise = ~prev_q & s_ior;
   assign rd_idle = prev_q & s_ior;

endmodule

// File: rtl/rxdma_interval_timer.sv
module rxdma_interval_timer #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] lim,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   assign last = lim - 1'b1;
   assign done = (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (!done)  cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/rxdma_ofs_ptr.sv
module rxdma_ofs_ptr #(
   parameter int SMALL_LOG2 = 14,
   parameter int BIG_LOG2   = 16,
   parameter int STEP       = 2,
   localparam int OFS_W     = BIG_LOG2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             big,
   output logic [OFS_W-1:0] ofs
);

   localparam logic [OFS_W-1:0] SMALL_MASK = OFS_W'((64'd1 << SMALL_LOG2) - 64'd1);
   localparam logic [OFS_W-1:0] BIG_MASK   = '1;

   logic [OFS_W-1:0] mask;
   logic [OFS_W-1:0] ofs_q;

   assign mask = big ? BIG_MASK : SMALL_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ofs_q <= '0;
      else if (clr)   ofs_q <= '0;
      else if (step)  ofs_q <= (ofs_q + OFS_W'(STEP)) & mask;
   end

   assign ofs = ofs_q;

endmodule

// File: rtl/rxdma_xfer_fsm.sv
module rxdma_xfer_fsm
   import rxdma_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter int CNT_W     = 10,
   parameter int BURST_CYC = 560,
   parameter int GAP_CYC   = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_single,
   input  logic             cfg_burst_lim,
   input  logic             cmd_reset,
   input  logic             frame_start,
   input  logic [LEN_W-1:0] frame_len,
   input  logic             dma_ack,
   input  logic             rd_fall,
   input  logic             rd_rise,
   input  logic             rd_idle,
   input  logic             tmr_done,
   output logic             tmr_clr,
   output logic [CNT_W-1:0] tmr_lim,
   output logic             rd_hit,
   output logic             req,
   output logic             rd_pulse,
   output logic             flush_pulse
);

   rxdma_state_e     st_q, st_d;
   logic [LEN_W-1:0] words_q, words_d;
   logic [LEN_W:0]   len_ext;
   logic [LEN_W-1:0] words_ld;

   assign len_ext  = {1'b0, frame_len} + 1'b1;
   assign words_ld = len_ext[LEN_W:1];

   always_comb begin
      st_d    = st_q;
      words_d = words_q;
      rd_hit  = 1'b0;
      tmr_clr = 1'b0;
      if (cmd_reset) begin
         st_d    = ST_IDLE;
         words_d = '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (frame_start && (frame_len != '0)) begin
                  st_d    = ST_REQ;
                  words_d = words_ld;
                  tmr_clr = 1'b1;
               end
            end
            ST_REQ: begin
               if (dma_ack && rd_fall) begin
                  rd_hit  = 1'b1;
                  words_d = words_q - 1'b1;
                  if (words_q == LEN_W'(1)) begin
                     st_d = cfg_single ? ST_IDLE : ST_DRAIN;
                  end
               end else if (cfg_burst_lim && tmr_done && rd_idle) begin
                  st_d    = ST_GAP;
                  tmr_clr = 1'b1;
               end
            end
            ST_DRAIN: begin
               if (rd_rise) st_d = ST_IDLE;
            end
            ST_GAP: begin
               if (tmr_done) begin
                  st_d    = ST_REQ;
                  tmr_clr = 1'b1;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   assign tmr_lim = (st_q == ST_GAP) ? CNT_W'(GAP_CYC) : CNT_W'(BURST_CYC);
   assign req     = (st_q == ST_REQ) || (st_q == ST_DRAIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         words_q     <= '0;
         rd_pulse    <= 1'b0;
         flush_pulse <= 1'b0;
      end else begin
         st_q        <= st_d;
         words_q     <= words_d;
         rd_pulse    <= rd_hit;
         flush_pulse <= cmd_reset;
      end
   end

endmodule

// File: rtl/rxdma_req_ctrl.sv
module rxdma_req_ctrl
   import rxdma_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 20_000_000,
   parameter int          LEN_W       = 16,
   parameter int          SMALL_LOG2  = 14,
   parameter int          BIG_LOG2    = 16,
   parameter int          SYNC_STAGES = 0,
   localparam int         OFS_W       = BIG_LOG2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_single,
   input  logic             cfg_burst_lim,
   input  logic             cfg_big_buf,
   input  logic             cmd_dma_reset,
   input  logic             frame_start,
   input  logic [LEN_W-1:0] frame_len,
   input  logic             dma_ack,
   input  logic             ior_n,
   output logic             dma_req,
   output logic [OFS_W-1:0] dma_ofs,
   output logic             buf_rd,
   output logic             buf_flush
);

   localparam int BURST_CYC = int'(cycles_for(64'd280, 64'(CLK_HZ)));
   localparam int GAP_CYC   = int'(cycles_for(64'd13, 64'(CLK_HZ)));
   localparam int CNT_W     = $clog2(BURST_CYC + 1);

   generate
      if (SMALL_LOG2 >= BIG_LOG2) begin : g_bad_sizes
         $error("SMALL_LOG2 must be below BIG_LOG2");
      end
      if (SMALL_LOG2 < 2) begin : g_bad_small
         $error("SMALL_LOG2 too small for a 2-byte step");
      end
      if (LEN_W < 2) begin : g_bad_len
         $error("LEN_W must be at least 2");
      end
      if (GAP_CYC < 2) begin : g_bad_clk
         $error("CLK_HZ too low for the hold-off window");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic             rd_fall, rd_rise, rd_idle;
   logic             tmr_clr, tmr_done, rd_hit;
   logic [CNT_W-1:0] tmr_lim;

   rxdma_strobe_edge #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .ior_n   (ior_n),
      .rd_fall (rd_fall),
      .rd_rise (rd_rise),
      .rd_idle (rd_idle)
   );

   rxdma_interval_timer #(
      .CNT_W (CNT_W)
   ) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .lim   (tmr_lim),
      .done  (tmr_done)
   );

   rxdma_xfer_fsm #(
      .LEN_W     (LEN_W),
      .CNT_W     (CNT_W),
      .BURST_CYC (BURST_CYC),
      .GAP_CYC   (GAP_CYC)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_single    (cfg_single),
      .cfg_burst_lim (cfg_burst_lim),
      .cmd_reset     (cmd_dma_reset),
      .frame_start   (frame_start),
      .frame_len     (frame_len),
      .dma_ack       (dma_ack),
      .rd_fall       (rd_fall),
      .rd_rise       (rd_rise),
      .rd_idle       (rd_idle),
      .tmr_done      (tmr_done),
      .tmr_clr       (tmr_clr),
      .tmr_lim       (tmr_lim),
      .rd_hit        (rd_hit),
      .req           (dma_req),
      .rd_pulse      (buf_rd),
      .flush_pulse   (buf_flush)
   );

   rxdma_ofs_ptr #(
      .SMALL_LOG2 (SMALL_LOG2),
      .BIG_LOG2   (BIG_LOG2),
      .STEP       (2)
   ) u_ofs (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cmd_dma_reset),
      .step  (rd_hit),
      .big   (cfg_big_buf),
      .ofs   (dma_ofs)
   );

endmodule

// File: rtl/rxdma_req_ctrl_chk.sv
module rxdma_req_ctrl_chk #(
   parameter int SMALL_LOG2 = 14,
   parameter int OFS_W      = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_single,
   input logic             cfg_burst_lim,
   input logic             cfg_big_buf,
   input logic             cmd_dma_reset,
   input logic             dma_ack,
   input logic             ior_n,
   input logic             dma_req,
   input logic [OFS_W-1:0] dma_ofs,
   input logic             buf_rd,
   input logic             buf_flush
);

   localparam logic [OFS_W-1:0] SMALL_MASK = OFS_W'((64'd1 << SMALL_LOG2) - 64'd1);

   function automatic logic [OFS_W-1:0] next_ofs(input logic [OFS_W-1:0] o, input logic big);
      logic [OFS_W-1:0] s;
      s = o + OFS_W'(2);
      return big ? s : (s & SMALL_MASK);
   endfunction

   // R3: a buffer read only follows an acknowledged, requested strobe fall
   assert_rd_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      buf_rd |-> ($past(dma_ack) && $past(dma_req) && !$past(ior_n)));

   // R6: each step lands on the wrapped next offset
   assert_ofs_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      buf_rd |-> (dma_ofs == next_ofs($past(dma_ofs), $past(cfg_big_buf))));

   // R3: no read and no reset command means the offset holds
   assert_ofs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_rd && !$past(cmd_dma_reset)) |-> $stable(dma_ofs));

   // R9: reset command aborts, zeroes and flushes
   assert_abort_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_dma_reset) |-> (buf_flush && !dma_req && (dma_ofs == '0) && !buf_rd));

   // R4: in demand mode the request only drops right after a strobe rise
   assert_demand_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dma_req) && !$past(cmd_dma_reset) && !$past(cfg_single) && !$past(cfg_burst_lim))
      |-> ($past(ior_n) && !$past(ior_n, 2)));

endmodule

bind rxdma_req_ctrl rxdma_req_ctrl_chk #(
   .SMALL_LOG2 (SMALL_LOG2),
   .OFS_W      (OFS_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_single    (cfg_single),
   .cfg_burst_lim (cfg_burst_lim),
   .cfg_big_buf   (cfg_big_buf),
   .cmd_dma_reset (cmd_dma_reset),
   .dma_ack       (dma_ack),
   .ior_n         (ior_n),
   .dma_req       (dma_req),
   .dma_ofs       (dma_ofs),
   .buf_rd        (buf_rd),
   .buf_flush     (buf_flush)
);

// File: tb/rxdma_req_ctrl_bench.sv
module rxdma_req_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int unsigned CLK_HZ = 20_000_000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_single = 1'b0, cfg_burst_lim = 1'b0, cfg_big_buf = 1'b0;
   logic        cmd_dma_reset = 1'b0, frame_start = 1'b0;
   logic [15:0] frame_len = '0;
   logic        dma_ack = 1'b0, ior_n = 1'b1;
   logic        dma_req;
   logic [15:0] dma_ofs;
   logic        buf_rd, buf_flush;

   int n_cmp = 0, n_bad = 0;
   bit done_flag = 0;
   int exp_ofs = 0, exp_words = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxdma_req_ctrl #(.CLK_HZ(CLK_HZ)) u_rxdma_req_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_single(cfg_single), .cfg_burst_lim(cfg_burst_lim),
      .cfg_big_buf(cfg_big_buf), .cmd_dma_reset(cmd_dma_reset), .frame_start(frame_start),
      .frame_len(frame_len), .dma_ack(dma_ack), .ior_n(ior_n), .dma_req(dma_req),
      .dma_ofs(dma_ofs), .buf_rd(buf_rd), .buf_flush(buf_flush));

   function automatic int ceil_cyc(input real secs);
      real c;
      int  n;
      c = secs * real'(CLK_HZ);
      n = int'($floor(c + 1.0e-6));
      if (real'(n) < c - 1.0e-6) n++;
      return n;
   endfunction

   function automatic int step_ofs(input int o, input bit big);
      return (o + 2) % (big ? 65536 : 16384);
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done_flag) begin
         done_flag = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // all tasks start and end just after a falling clock edge
   task automatic start_frame(input int len);
      frame_start = 1'b1; frame_len = 16'(len);
      @(negedge clk);
      frame_start = 1'b0;
      if (exp_words == 0 && len != 0) exp_words = (len + 1) / 2;
   endtask

   task automatic host_read(input bit ack_on, input int hold, input bit full);
      bit hit, last;
      hit  = ack_on && (exp_words > 0);
      dma_ack = ack_on; ior_n = 1'b0;
      @(negedge clk);
      if (hit) begin
         exp_ofs = step_ofs(exp_ofs, cfg_big_buf);
         exp_words--;
      end
      last = hit && (exp_words == 0);
      if (full || !hit || last) begin
         chk("R3 buf_rd", buf_rd, hit);
         chk("R6 dma_ofs", dma_ofs, exp_ofs);
      end else if (dma_ofs != 16'(exp_ofs) || !buf_rd) begin
         chk("R6 dma_ofs stream", dma_ofs, exp_ofs);
      end
      if (last) chk(cfg_single ? "R5 early release" : "R4 held to rise", dma_req, !cfg_single);
      repeat (hold) @(negedge clk);
      ior_n = 1'b1;
      @(negedge clk);
      if (last) begin
         chk("R4/R5 released", dma_req, 0);
         chk("R3 single pulse", buf_rd, 0);
      end
      if (cfg_single || last) dma_ack = 1'b0;
   endtask

   initial begin
      repeat (195_000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      int run;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 req", dma_req, 0);
      chk("R1 ofs", dma_ofs, 0);
      chk("R1 buf_rd", buf_rd, 0);
      chk("R1 flush", buf_flush, 0);

      // R2 zero length ignored
      start_frame(0);
      repeat (3) @(negedge clk);
      chk("R2 zero len", dma_req, 0);

      // R4 demand mode, odd length
      cfg_single = 0;
      start_frame(5);
      chk("R2 req rises", dma_req, 1);
      host_read(1, 1, 1);
      host_read(1, 0, 1);
      host_read(1, 3, 1);

      // R5 single mode with an unacknowledged strobe between reads
      cfg_single = 1;
      start_frame(4);
      host_read(1, 0, 1);
      host_read(0, 0, 1);
      chk("R3 ack low keeps req", dma_req, 1);
      host_read(1, 0, 1);

      // R10 frame_start while busy is ignored
      start_frame(2);
      start_frame(10);
      host_read(1, 0, 1);
      repeat (2) @(negedge clk);
      chk("R10 no restart", dma_req, 0);

      // R9 abort mid-frame
      cfg_single = 0;
      start_frame(10);
      host_read(1, 0, 1);
      host_read(1, 0, 1);
      cmd_dma_reset = 1'b1;
      @(negedge clk);
      cmd_dma_reset = 1'b0;
      exp_ofs = 0; exp_words = 0;
      chk("R9 req", dma_req, 0);
      chk("R9 ofs", dma_ofs, 0);
      chk("R9 flush", buf_flush, 1);
      @(negedge clk);
      chk("R9 flush pulse", buf_flush, 0);
      host_read(1, 0, 1);
      dma_ack = 1'b0;
      repeat (10) @(negedge clk);
      chk("R9 stays low", dma_req, 0);

      // R8 burst limiting
      cfg_burst_lim = 1; cfg_single = 1;
      start_frame(4);
      run = 0;
      while (dma_req && run < 5000) begin run++; @(negedge clk); end
      chk("R8 window", run, ceil_cyc(28.0e-6));
      run = 0;
      while (!dma_req && run < 5000) begin run++; @(negedge clk); end
      chk("R8 hold-off", run, ceil_cyc(1.3e-6));
      host_read(1, 0, 1);
      host_read(1, 0, 1);
      cfg_burst_lim = 0;

      // random frames
      for (int f = 0; f < 40; f++) begin
         cfg_single  = 1'($urandom_range(0, 1));
         cfg_big_buf = 1'($urandom_range(0, 1));
         if ($urandom_range(0, 7) == 0) begin
            start_frame(0);
            @(negedge clk);
            chk("R2 zero len rnd", dma_req, 0);
         end else begin
            start_frame($urandom_range(1, 24));
            while (exp_words > 0) begin
               if (cfg_single && $urandom_range(0, 3) == 0) host_read(0, 0, 1);
               else begin
                  if (!cfg_single) chk("R7 req held", dma_req, 1);
                  host_read(1, $urandom_range(0, 2), 1);
               end
            end
         end
      end

      // R6/R7 long frames: 16 KB ring wraps, then 64 KB ring wraps
      cmd_dma_reset = 1'b1; @(negedge clk); cmd_dma_reset = 1'b0;
      exp_ofs = 0; exp_words = 0;
      cfg_single = 0; cfg_big_buf = 0;
      start_frame(16384);
      while (exp_words > 1) begin
         if (!dma_req) chk("R7 long frame req", dma_req, 1);
         host_read(1, 0, 0);
      end
      host_read(1, 0, 1);
      chk("R6 16K wrap", dma_ofs, 0);
      cfg_big_buf = 1;
      start_frame(65534);
      while (exp_words > 1) begin
         if (!dma_req) chk("R7 long frame req", dma_req, 1);
         host_read(1, 0, 0);
      end
      host_read(1, 0, 1);
      chk("R6 64K top", dma_ofs, 65534);
      start_frame(2);
      host_read(1, 0, 1);
      chk("R6 64K wrap", dma_ofs, 0);

      summary();
   end

endmodule